// File: doc/BRIEF.md
# Bus-Mapped Real-Time Clock with Alarm

This peripheral keeps a seconds count for a system. An external strobe pulses once per second, and each pulse advances a 32-bit counter by one. Software reaches the block through a small 32-bit register bus. The bus has a select, a write flag, a byte address, write data and read data. Software can read the count, replace it through a load register, and program a match value that raises an alarm.

The alarm is a single interrupt source. A sticky raw status bit, a one-bit mask and a masked status drive the interrupt pin. Writing any value to the clear register drops the raw bit. The top 32 bytes of the 4 KB window return fixed identification bytes, one per word. A control register always reports that the clock is running.

Writes take effect at the rising clock edge when select and write are both high. With the default build, read data is combinational from the address while select is high and write is low. Read data is zero at all other times.

Top module: `rtc_alarm_top`

## Requirements
- R1: After the active-low synchronous reset, the count, match, load, mask and raw status read zero, and irq is low.
- R2: A read at offset 0x00 returns the current count. A write to 0x00 leaves the count unchanged.
- R3: Each cycle with tick high advances the count by one, modulo 2^32, so 0xFFFFFFFF is followed by 0x00000000. Without a tick or a load, the count holds.
- R4: A write to offset 0x08 replaces the count with the write data. A read of 0x08 returns the last value written there, and this value does not follow later ticks.
- R5: The raw status (bit 0 at offset 0x14) sets when a tick moves the count onto the match value (offset 0x04). The comparison wraps across rollover, and the bit stays set until it is cleared.
- R6: A write to match or load that leaves the count equal to the match value sets the raw status in that same cycle.
- R7: Any write to offset 0x1C clears the raw status, whatever the data. If a new match occurs in the same cycle as the clear, the status stays set.
- R8: Only bit 0 of the mask register (offset 0x10) is stored, and the upper bits read zero. Offset 0x18 reads raw AND mask, and irq equals that value.
- R9: Offset 0x0C always reads 1. Writes to 0x0C, 0x14 and 0x18 change nothing.
- R10: Reads at 0xFE0 through 0xFFC return, one byte per word in rising address order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of 0x1C and of undefined offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that sec_tick and the bus inputs are stable around each rising edge, so that every strobe or write is seen by exactly one edge. The bench drives all inputs on the falling edge and holds each tick and each write for exactly one cycle. It releases reset only after several edges. It combines a tick with a write only in the one scenario that checks which event has priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // Register word indices (byte offset / 4); these positions are the bus map.
   localparam int unsigned WIDX_COUNT = 0;
   localparam int unsigned WIDX_MATCH = 1;
   localparam int unsigned WIDX_LOAD  = 2;
   localparam int unsigned WIDX_CTRL  = 3;
   localparam int unsigned WIDX_MASK  = 4;
   localparam int unsigned WIDX_RAW   = 5;
   localparam int unsigned WIDX_MSTAT = 6;
   localparam int unsigned WIDX_CLEAR = 7;

   // Number of identification words at the top of the window.
   localparam int unsigned ID_WORDS = 8;

   typedef enum logic [3:0] {
      RSEL_NONE,
      RSEL_COUNT,
      RSEL_MATCH,
      RSEL_LOAD,
      RSEL_CTRL,
      RSEL_MASK,
      RSEL_RAW,
      RSEL_MSTAT,
      RSEL_CLEAR,
      RSEL_IDENT
   } rtc_rsel_e;

   function automatic logic [7:0] ident_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0:    b = 8'h31;
         3'd1:    b = 8'h10;
         3'd2:    b = 8'h14;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned WINDOW_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output rtc_rsel_e         rsel,
   output logic [2:0]        id_idx
);
   localparam int unsigned WORD_W = WINDOW_W - 2;
   localparam int unsigned ID_TOP = WORD_W - 3;

   generate
      if (ADDR_W < WINDOW_W) begin : g_bad_addr
         $error("rtc_decode: ADDR_W must cover the register window");
      end
      if (WINDOW_W < 6) begin : g_bad_window
         $error("rtc_decode: WINDOW_W too small for the ident block");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   assign word   = addr[WINDOW_W-1:2];
   assign id_idx = word[2:0];

   always_comb begin
      rsel = RSEL_NONE;
      if (&word[WORD_W-1:3]) begin
         rsel = RSEL_IDENT;
      end else if (word[WORD_W-1:3] == '0) begin
         case (word[2:0])
            3'(WIDX_COUNT): rsel = RSEL_COUNT;
            3'(WIDX_MATCH): rsel = RSEL_MATCH;
            3'(WIDX_LOAD):  rsel = RSEL_LOAD;
            3'(WIDX_CTRL):  rsel = RSEL_CTRL;
            3'(WIDX_MASK):  rsel = RSEL_MASK;
            3'(WIDX_RAW):   rsel = RSEL_RAW;
            3'(WIDX_MSTAT): rsel = RSEL_MSTAT;
            default:        rsel = RSEL_CLEAR;
         endcase
      end
   end

   // Unused upper address bits are ignored: the window repeats.
   logic unused_hi;
   generate
      if (ADDR_W > WINDOW_W) begin : g_hi
         assign unused_hi = ^addr[ADDR_W-1:WINDOW_W];
      end else begin : g_nohi
         assign unused_hi = 1'b0;
      end
   endgenerate
   logic unused_lo;
   assign unused_lo = ^addr[1:0] ^ unused_hi;

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_we,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] load_q,
   output logic [CNT_W-1:0] count_nxt
);
   generate
      if (CNT_W < 8) begin : g_bad_w
         $error("rtc_counter: CNT_W must be at least 8");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      if (load_we)   count_nxt = load_val;
      else if (tick) count_nxt = count + ONE;
      else           count_nxt = count;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         load_q <= '0;
      end else begin
         count <= count_nxt;
         if (load_we) load_q <= load_val;
      end
   end

   // R4: a load replaces the count on the next edge
   a_r4_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> (count == $past(load_val)));

   // R3: a tick without a load adds one, wrapping
   a_r3_tick_adds: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_we) |=> (count == $past(count) + ONE));

   // R3: no tick and no load keeps the count
   a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_we) |=> $stable(count));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_we,
   input  logic             match_we,
   input  logic             clear_we,
   input  logic             mask_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] count_nxt,
   output logic [CNT_W-1:0] match_q,
   output logic             raw,
   output logic             mask
);
   logic [CNT_W-1:0] match_nxt;
   logic             event_any;
   logic             hit;

   assign match_nxt = match_we ? wdata : match_q;
   assign event_any = tick | load_we | match_we;
   assign hit       = event_any && (count_nxt == match_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= '0;
         raw     <= 1'b0;
         mask    <= 1'b0;
      end else begin
         match_q <= match_nxt;
         if (hit)           raw <= 1'b1;
         else if (clear_we) raw <= 1'b0;
         if (mask_we)       mask <= wdata[0];
      end
   end

   // R7: a clear with no concurrent match drops the status
   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_we && !hit) |=> !raw);

   // R5: raw status is sticky until cleared
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (raw && !clear_we) |=> raw);

   // R8: mask stores bit 0 of the written data
   a_r8_mask_bit: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask == $past(wdata[0])));

endmodule

// File: rtl/rtc_readmux.sv
module rtc_readmux
   import rtc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  rtc_rsel_e         rsel,
   input  logic [2:0]        id_idx,
   input  logic [DATA_W-1:0] count,
   input  logic [DATA_W-1:0] match_q,
   input  logic [DATA_W-1:0] load_q,
   input  logic              raw,
   input  logic              mask,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PAD_W = DATA_W - 8;

   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      if (rd_en) begin
         case (rsel)
            RSEL_COUNT: mux = count;
            RSEL_MATCH: mux = match_q;
            RSEL_LOAD:  mux = load_q;
            RSEL_CTRL:  mux = DATA_W'(1);
            RSEL_MASK:  mux = DATA_W'(mask);
            RSEL_RAW:   mux = DATA_W'(raw);
            RSEL_MSTAT: mux = DATA_W'(raw & mask);
            RSEL_IDENT: mux = {{PAD_W{1'b0}}, ident_byte(id_idx)};
            default:    mux = '0;
         endcase
      end
   end

   generate
      if (REG_RDATA) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= mux;
         end
      end else begin : g_comb
         assign rdata = mux;
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
      end
   endgenerate

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
   import rtc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter bit          REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned WINDOW_W = 12;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("rtc_alarm_top: DATA_W must hold an ident byte");
      end
   endgenerate

   rtc_rsel_e         rsel;
   logic [2:0]        id_idx;
   logic              wr_go, rd_go;
   logic              load_we, match_we, clear_we, mask_we;
   logic [DATA_W-1:0] count, load_q, count_nxt, match_q;
   logic              raw, mask;

   assign wr_go    = bus_sel & bus_wr;
   assign rd_go    = bus_sel & ~bus_wr;
   assign load_we  = wr_go && (rsel == RSEL_LOAD);
   assign match_we = wr_go && (rsel == RSEL_MATCH);
   assign clear_we = wr_go && (rsel == RSEL_CLEAR);
   assign mask_we  = wr_go && (rsel == RSEL_MASK);

   rtc_decode #(.ADDR_W(ADDR_W), .WINDOW_W(WINDOW_W)) u_dec (
      .addr   (bus_addr),
      .rsel   (rsel),
      .id_idx (id_idx)
   );

   rtc_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .load_we   (load_we),
      .load_val  (bus_wdata),
      .count     (count),
      .load_q    (load_q),
      .count_nxt (count_nxt)
   );

   rtc_alarm #(.CNT_W(DATA_W)) u_alm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .load_we   (load_we),
      .match_we  (match_we),
      .clear_we  (clear_we),
      .mask_we   (mask_we),
      .wdata     (bus_wdata),
      .count_nxt (count_nxt),
      .match_q   (match_q),
      .raw       (raw),
      .mask      (mask)
   );

   rtc_readmux #(.DATA_W(DATA_W), .REG_RDATA(REG_RDATA)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_go),
      .rsel    (rsel),
      .id_idx  (id_idx),
      .count   (count),
      .match_q (match_q),
      .load_q  (load_q),
      .raw     (raw),
      .mask    (mask),
      .rdata   (bus_rdata)
   );

   assign irq = raw & mask;

   // R6: a match write equal to the resulting count raises status at once
   a_r6_match_write_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (match_we && !load_we && !sec_tick && (bus_wdata == count)) |=> raw);

   // R9: writes to the status offsets never touch the count
   a_r9_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && (rsel == RSEL_RAW || rsel == RSEL_MSTAT || rsel == RSEL_CTRL)
       && !sec_tick) |=> $stable(count));

endmodule

// File: tb/rtc_alarm_top_tb.sv
module rtc_alarm_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   rtc_alarm_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_tick  (sec_tick),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = tk;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2;
      check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic irq_check(input string req, input logic exp);
      @(negedge clk);
      #2;
      check(req, 32'(irq), 32'(exp));
   endtask

   task automatic t_reset();
      rd_check("R1 count", 12'h000, 32'h0);
      rd_check("R1 match", 12'h004, 32'h0);
      rd_check("R1 load",  12'h008, 32'h0);
      rd_check("R1 mask",  12'h010, 32'h0);
      rd_check("R1 raw",   12'h014, 32'h0);
      irq_check("R1 irq", 1'b0);
   endtask

   task automatic t_data_reg();
      wr(12'h000, 32'h1234, 1'b0);
      rd_check("R2 write ignored", 12'h000, 32'h0);
      tick(); tick(); tick();
      rd_check("R2 count read", 12'h000, 32'd3);
   endtask

   task automatic t_wrap();
      wr(12'h008, 32'hFFFF_FFFE, 1'b0);
      tick();
      rd_check("R3 increment", 12'h000, 32'hFFFF_FFFF);
      tick();
      rd_check("R3 rollover", 12'h000, 32'h0);
      rd_check("R3 hold", 12'h000, 32'h0);
   endtask

   task automatic t_load();
      wr(12'h008, 32'h100, 1'b0);
      rd_check("R4 count loaded", 12'h000, 32'h100);
      tick();
      rd_check("R4 load readback", 12'h008, 32'h100);
      rd_check("R4 counts on", 12'h000, 32'h101);
   endtask

   task automatic t_tick_match();
      wr(12'h01C, 32'h0, 1'b0);
      wr(12'h008, 32'h10, 1'b0);
      wr(12'h004, 32'h12, 1'b0);
      rd_check("R5 idle", 12'h014, 32'h0);
      tick();
      rd_check("R5 before match", 12'h014, 32'h0);
      tick();
      rd_check("R5 match sets", 12'h014, 32'h1);
      tick();
      rd_check("R5 sticky", 12'h014, 32'h1);
      // wrap-around match
      wr(12'h004, 32'h1, 1'b0);
      wr(12'h008, 32'hFFFF_FFFF, 1'b0);
      wr(12'h01C, 32'h0, 1'b0);
      tick();
      rd_check("R5 wrap not yet", 12'h014, 32'h0);
      tick();
      rd_check("R5 wrap match", 12'h014, 32'h1);
   endtask

   task automatic t_write_match();
      wr(12'h01C, 32'h0, 1'b0);
      wr(12'h008, 32'h50, 1'b0);
      rd_check("R6 no hit", 12'h014, 32'h0);
      wr(12'h004, 32'h50, 1'b0);
      rd_check("R6 match write hit", 12'h014, 32'h1);
      wr(12'h01C, 32'h0, 1'b0);
      wr(12'h004, 32'h60, 1'b0);
      rd_check("R6 cleared", 12'h014, 32'h0);
      wr(12'h008, 32'h60, 1'b0);
      rd_check("R6 load write hit", 12'h014, 32'h1);
   endtask

   task automatic t_clear();
      wr(12'h01C, 32'h0, 1'b0);
      rd_check("R7 clear any data", 12'h014, 32'h0);
      wr(12'h008, 32'h70, 1'b0);
      wr(12'h004, 32'h71, 1'b0);
      wr(12'h01C, 32'hFFFF_FFFF, 1'b1);
      rd_check("R7 set wins", 12'h014, 32'h1);
   endtask

   task automatic t_mask();
      rd_check("R8 masked off", 12'h018, 32'h0);
      irq_check("R8 irq masked", 1'b0);
      wr(12'h010, 32'hFFFF_FFFF, 1'b0);
      rd_check("R8 mask bit0 only", 12'h010, 32'h1);
      rd_check("R8 masked status", 12'h018, 32'h1);
      irq_check("R8 irq high", 1'b1);
      wr(12'h01C, 32'h0, 1'b0);
      rd_check("R8 masked cleared", 12'h018, 32'h0);
      irq_check("R8 irq low", 1'b0);
   endtask

   task automatic t_ctrl();
      rd_check("R9 ctrl one", 12'h00C, 32'h1);
      wr(12'h00C, 32'h0, 1'b0);
      rd_check("R9 ctrl after write", 12'h00C, 32'h1);
      wr(12'h014, 32'hFFFF_FFFF, 1'b0);
      rd_check("R9 raw write inert", 12'h014, 32'h0);
      wr(12'h018, 32'hFFFF_FFFF, 1'b0);
      rd_check("R9 mstat write inert", 12'h018, 32'h0);
      rd_check("R9 count kept", 12'h000, 32'h71);
   endtask

   task automatic t_ident();
      logic [7:0] exp_b [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++) begin
         rd_check("R10 ident", 12'hFE0 + 12'(i * 4), {24'h0, exp_b[i]});
      end
   endtask

   task automatic t_undef();
      rd_check("R11 clear reads zero", 12'h01C, 32'h0);
      rd_check("R11 undefined 0x20", 12'h020, 32'h0);
      rd_check("R11 undefined 0x800", 12'h800, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data_reg();
      t_wrap();
      t_load();
      t_tick_match();
      t_write_match();
      t_clear();
      t_mask();
      t_ctrl();
      t_ident();
      t_undef();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule